// File: doc/BRIEF.md
# Register-Mapped Factorial Accelerator

This block is a small slave register file on a simple single-cycle read/write port. It holds a read-only identification word, a liveness register that returns the complement of what was last stored in it, and a factorial unit. A 32-bit write of `n` to the factorial register starts a sequential multiply loop. When the loop finishes, n! (kept to its low 32 bits) overwrites the value in that same register.

Software starts a computation by writing the operand. It then polls the busy bit in the status register until it clears, and reads the result back from the operand's own address. It can also set the completion-interrupt enable bit in the status register. The block then emits a one-cycle request pulse, tagged with code 0x00000001, toward an interrupt collector when the result lands. Only 32-bit accesses are accepted in the register window below 0x80.

Top module: `fact_regblk`

## Requirements
- R1: A read of offset 0x00 returns {VER_MAJ[7:0], VER_MIN[7:0], 16'h00ED}. Writes to it have no effect.
- R2: A read of offset 0x04 returns the bitwise complement of the last value written there. After reset the stored value is 0, so the read returns 0xFFFFFFFF.
- R3: A write of n to offset 0x08 while idle starts a factorial computation. The result replaces the register value max(n,1) clock edges after the write edge. Inputs 0 and 1 both yield 1.
- R4: The result is n! truncated to its low 32 bits (for example, 13 gives 1932053504).
- R5: Status offset 0x20 bit 0 is the busy flag. It reads 1 from the write edge until the result lands. Writes cannot change it.
- R6: Status bit 7 is a read/write interrupt enable that resets to 0. When it is set, the block emits a one-cycle `irq_pulse` with `irq_val` = 0x00000001 in the cycle after the result lands. When it is clear there is no pulse. `irq_val` is 0 whenever `irq_pulse` is low.
- R7: A write to offset 0x08 while busy is ignored. The running computation finishes with its original operand.
- R8: An access below 0x80 with `req_wide` = 1 (a 64-bit access), or with an address not 4-byte aligned, is illegal. An illegal write changes nothing, and an illegal read returns 0xFFFFFFFF.
- R9: A read of any offset other than 0x00, 0x04, 0x08 or 0x20 returns 0xFFFFFFFF.
- R10: Read data appears on `rd_data` with `rd_valid` = 1 in the cycle after the read request edge. `rd_valid` is 0 after writes and idle cycles.
- R11: Reset clears the factorial register, the liveness register, the busy flag, the interrupt enable and `irq_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| req_addr | input | ADDR_W | Byte offset in the window |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| irq_pulse | output | 1 | One-cycle completion request |
| irq_val | output | 32 | Status code carried by the request |

## Verification
Read data is registered, so the bench samples `rd_data` on the falling edge after the request's rising edge. A status read issued right after a factorial write must therefore show busy. The result lands max(n,1) edges after the write edge, and the bench reads it back only after waiting n+1 further idle cycles. The interrupt pulse is due exactly on the edge where the result lands. The bench checks `irq_pulse` on every falling edge after the start, so an early, late or doubled pulse shows up.

// File: rtl/fact_pkg.sv
package fact_pkg;

    localparam int DATA_W = 32;

    localparam logic [7:0] OFF_IDENT = 8'h00;
    localparam logic [7:0] OFF_ALIVE = 8'h04;
    localparam logic [7:0] OFF_FACT  = 8'h08;
    localparam logic [7:0] OFF_STAT  = 8'h20;
    localparam logic [7:0] NARROW_LIMIT = 8'h80;

    localparam int STAT_BUSY_BIT  = 0;
    localparam int STAT_IRQEN_BIT = 7;

    localparam logic [DATA_W-1:0] IRQ_DONE_CODE = 32'h0000_0001;
    localparam logic [15:0]       IDENT_TAG     = 16'h00ED;
    localparam logic [DATA_W-1:0] ALL_ONES      = '1;

    typedef struct packed {
        logic ident;
        logic alive;
        logic fact;
        logic stat;
    } reg_sel_t;

    typedef enum logic {
        ENG_IDLE = 1'b0,
        ENG_RUN  = 1'b1
    } eng_state_t;

    function automatic logic [DATA_W-1:0] make_status(input logic busy, input logic irq_en);
        logic [DATA_W-1:0] s;
        s = '0;
        s[STAT_BUSY_BIT]  = busy;
        s[STAT_IRQEN_BIT] = irq_en;
        return s;
    endfunction

endpackage

// File: rtl/fact_decode.sv
module fact_decode
    import fact_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              valid,
    input  logic              wide,
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);
    localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(NARROW_LIMIT);

    logic legal;

    always_comb begin
        legal     = valid && !wide && (addr < LIMIT) && (addr[1:0] == 2'b00);
        sel.ident = legal && (addr == ADDR_W'(OFF_IDENT));
        sel.alive = legal && (addr == ADDR_W'(OFF_ALIVE));
        sel.fact  = legal && (addr == ADDR_W'(OFF_FACT));
        sel.stat  = legal && (addr == ADDR_W'(OFF_STAT));
    end
endmodule

// File: rtl/fact_engine.sv
module fact_engine
    import fact_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] operand,
    output logic         busy,
    output logic         finish,
    output logic [W-1:0] result
);
    localparam logic [W-1:0] ONE = W'(1);

    eng_state_t   state_q;
    logic [W-1:0] acc_q;
    logic [W-1:0] cnt_q;

    assign busy   = (state_q == ENG_RUN);
    assign finish = busy && (cnt_q <= ONE);
    assign result = acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ENG_IDLE;
            acc_q   <= ONE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ENG_IDLE: begin
                    if (start) begin
                        acc_q   <= ONE;
                        cnt_q   <= operand;
                        state_q <= ENG_RUN;
                    end
                end
                ENG_RUN: begin
                    if (cnt_q <= ONE) begin
                        state_q <= ENG_IDLE;
                    end else begin
                        acc_q <= acc_q * cnt_q;
                        cnt_q <= cnt_q - ONE;
                    end
                end
                default: state_q <= ENG_IDLE;
            endcase
        end
    end

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        busy && !finish |=> cnt_q == $past(cnt_q) - ONE);

    // R5
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy && !finish |=> busy);

    // R3
    start_load_chk: assert property (@(posedge clk) disable iff (rst)
        start && !busy |=> busy && acc_q == ONE);
endmodule

// File: rtl/fact_regblk.sv
module fact_regblk
    import fact_pkg::*;
#(
    parameter int          ADDR_W  = 20,
    parameter logic [7:0]  VER_MAJ = 8'h01,
    parameter logic [7:0]  VER_MIN = 8'h00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_wide,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    output logic              irq_pulse,
    output logic [31:0]       irq_val
);
    localparam logic [DATA_W-1:0] IDENT_WORD = {VER_MAJ, VER_MIN, IDENT_TAG};

    reg_sel_t          sel;
    logic              wr_en;
    logic              rd_en;
    logic              eng_start;
    logic              eng_busy;
    logic              eng_finish;
    logic [DATA_W-1:0] eng_result;

    logic [DATA_W-1:0] alive_q;
    logic [DATA_W-1:0] fact_q;
    logic              irq_en_q;
    logic              irq_q;
    logic              rd_valid_q;
    logic [DATA_W-1:0] rd_data_q;
    logic [DATA_W-1:0] rd_mux;

    fact_decode #(.ADDR_W(ADDR_W)) u_dec (
        .valid (req_valid),
        .wide  (req_wide),
        .addr  (req_addr),
        .sel   (sel)
    );

    assign wr_en     = req_valid && req_write;
    assign rd_en     = req_valid && !req_write;
    assign eng_start = wr_en && sel.fact && !eng_busy;

    fact_engine #(.W(DATA_W)) u_eng (
        .clk     (clk),
        .rst     (rst),
        .start   (eng_start),
        .operand (req_wdata),
        .busy    (eng_busy),
        .finish  (eng_finish),
        .result  (eng_result)
    );

    always_comb begin
        rd_mux = ALL_ONES;
        if (sel.ident)      rd_mux = IDENT_WORD;
        else if (sel.alive) rd_mux = ~alive_q;
        else if (sel.fact)  rd_mux = fact_q;
        else if (sel.stat)  rd_mux = make_status(eng_busy, irq_en_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            alive_q    <= '0;
            fact_q     <= '0;
            irq_en_q   <= 1'b0;
            irq_q      <= 1'b0;
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
        end else begin
            if (wr_en && sel.alive) alive_q <= req_wdata;
            if (wr_en && sel.stat)  irq_en_q <= req_wdata[STAT_IRQEN_BIT];
            if (eng_finish)         fact_q <= eng_result;
            else if (eng_start)     fact_q <= req_wdata;
            irq_q      <= eng_finish && irq_en_q;
            rd_valid_q <= rd_en;
            if (rd_en) rd_data_q <= rd_mux;
        end
    end

    assign rd_valid  = rd_valid_q;
    assign rd_data   = rd_data_q;
    assign irq_pulse = irq_q;
    assign irq_val   = irq_q ? IRQ_DONE_CODE : '0;

    // R7
    busy_wr_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        eng_busy && wr_en && sel.fact && !eng_finish |=> $stable(fact_q));

    // R6
    irq_single_chk: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |=> !irq_pulse);

    // R6
    irq_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> $fell(eng_busy));

    // R8
    wide_wr_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_write && req_wide |=> $stable(alive_q) && $stable(irq_en_q));

    // R10
    rd_follow_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_write |=> !rd_valid);
endmodule

// File: tb/sim_fact_regblk.sv
module sim_fact_regblk;
    localparam int AW = 20;
    localparam logic [AW-1:0] A_ID   = 20'h00000;
    localparam logic [AW-1:0] A_LIVE = 20'h00004;
    localparam logic [AW-1:0] A_FACT = 20'h00008;
    localparam logic [AW-1:0] A_STAT = 20'h00020;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic rd_valid, irq_pulse;
    logic [31:0] rd_data, irq_val;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    fact_regblk #(.ADDR_W(AW), .VER_MAJ(8'h01), .VER_MIN(8'h00)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .irq_pulse(irq_pulse), .irq_val(irq_val)
    );

    localparam int NV = 8;
    localparam logic [31:0] VEC_N   [NV] = '{32'd0, 32'd1, 32'd2, 32'd5, 32'd10, 32'd12, 32'd13, 32'd14};
    localparam logic [31:0] VEC_EXP [NV] = '{32'd1, 32'd1, 32'd2, 32'd120, 32'd3628800,
                                             32'd479001600, 32'd1932053504, 32'd1278945280};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_op(input logic wr, input logic wide, input logic [AW-1:0] a, input logic [31:0] d);
        req_valid = 1'b1; req_write = wr; req_wide = wide; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_wide = 1'b0;
    endtask

    task automatic wr32(input logic [AW-1:0] a, input logic [31:0] d);
        bus_op(1'b1, 1'b0, a, d);
    endtask

    task automatic rd_chk(input string req, input logic wide, input logic [AW-1:0] a, input logic [31:0] exp);
        bus_op(1'b0, wide, a, 32'h0);
        check(req, {31'b0, rd_valid}, 32'd1);
        check(req, rd_data, exp);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL R10 watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        idle(2);
        rst = 1'b0;
        // R11 reset state
        check("R11 rd_valid", {31'b0, rd_valid}, 32'd0);
        check("R11 irq", {31'b0, irq_pulse}, 32'd0);
        rd_chk("R11 status", 1'b0, A_STAT, 32'h0);
        rd_chk("R11 fact", 1'b0, A_FACT, 32'h0);
        rd_chk("R2 R11 alive", 1'b0, A_LIVE, 32'hFFFF_FFFF);

        // R1 identification, write ignored
        rd_chk("R1 ident", 1'b0, A_ID, 32'h0100_00ED);
        wr32(A_ID, 32'h1234_5678);
        check("R10 no rd_valid after write", {31'b0, rd_valid}, 32'd0);
        rd_chk("R1 ident after write", 1'b0, A_ID, 32'h0100_00ED);

        // R2 liveness
        wr32(A_LIVE, 32'hA5A5_0F0F);
        rd_chk("R2 alive", 1'b0, A_LIVE, 32'h5A5A_F0F0);
        wr32(A_LIVE, 32'h0000_0000);
        rd_chk("R2 alive zero", 1'b0, A_LIVE, 32'hFFFF_FFFF);

        // R3 R4 R5 table of factorials
        for (int v = 0; v < NV; v++) begin
            wr32(A_FACT, VEC_N[v]);
            rd_chk("R5 busy after start", 1'b0, A_STAT, 32'h0000_0001);
            idle(int'(VEC_N[v]) + 1);
            rd_chk("R3 R4 result", 1'b0, A_FACT, VEC_EXP[v]);
            rd_chk("R5 busy cleared", 1'b0, A_STAT, 32'h0);
        end

        // R5 busy bit is not writable
        wr32(A_STAT, 32'h0000_0081);
        rd_chk("R5 R6 status write", 1'b0, A_STAT, 32'h0000_0080);

        // R6 interrupt enabled: pulse exactly on the landing edge (3 edges after start)
        wr32(A_FACT, 32'd3);
        check("R6 no early pulse", {31'b0, irq_pulse}, 32'd0);
        for (int i = 1; i <= 4; i++) begin
            @(posedge clk);
            @(negedge clk);
            check("R6 pulse timing", {31'b0, irq_pulse}, (i == 3) ? 32'd1 : 32'd0);
            check("R6 pulse code", irq_val, (i == 3) ? 32'h0000_0001 : 32'h0);
        end
        rd_chk("R3 fact 3", 1'b0, A_FACT, 32'd6);

        // R6 interrupt disabled: no pulse
        wr32(A_STAT, 32'h0);
        rd_chk("R6 enable cleared", 1'b0, A_STAT, 32'h0);
        wr32(A_FACT, 32'd3);
        begin
            int seen;
            seen = 0;
            for (int i = 0; i < 6; i++) begin
                @(posedge clk);
                @(negedge clk);
                if (irq_pulse) seen++;
            end
            check("R6 no pulse when disabled", seen, 32'd0);
        end

        // R7 write while busy ignored
        wr32(A_FACT, 32'd10);
        wr32(A_FACT, 32'd3);
        idle(12);
        rd_chk("R7 busy write ignored", 1'b0, A_FACT, 32'd3628800);

        // R8 illegal accesses below 0x80
        wr32(A_LIVE, 32'h0000_00FF);
        bus_op(1'b1, 1'b1, A_LIVE, 32'h1111_1111);
        rd_chk("R8 wide write ignored", 1'b0, A_LIVE, 32'hFFFF_FF00);
        rd_chk("R8 wide read", 1'b1, A_ID, 32'hFFFF_FFFF);
        rd_chk("R8 unaligned read", 1'b0, 20'h00005, 32'hFFFF_FFFF);
        bus_op(1'b1, 1'b0, 20'h00005, 32'h2222_2222);
        rd_chk("R8 unaligned write ignored", 1'b0, A_LIVE, 32'hFFFF_FF00);

        // R9 unmapped offsets
        rd_chk("R9 hole 0x40", 1'b0, 20'h00040, 32'hFFFF_FFFF);
        rd_chk("R9 above 0x80", 1'b0, 20'h00080, 32'hFFFF_FFFF);
        rd_chk("R9 far offset", 1'b0, 20'hFFFFC, 32'hFFFF_FFFF);

        // R10 rd_valid drops on idle cycle
        idle(1);
        check("R10 rd_valid idle", {31'b0, rd_valid}, 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule